// File: doc/BRIEF.md
# Controller Command Responder with Seconds Clock

This block is the command stage of a device-side controller. A handshake front end hands it one received packet at a time: a type byte, a command byte and up to four argument bytes. The responder decodes the command, updates its own state and, one clock later, presents a complete reply packet for the front end to shift out to the host.

The responder keeps a 32-bit seconds count whose zero lies at the start of 1904. It advances once for each pulse on a one-per-second tick input. The host can set this count or read it back, and both transfers are big-endian. A polling command turns a periodic tick at `POLL_HZ` (50 Hz by default) on or off; that tick is derived from the core clock. A small set of configuration commands is acknowledged and has no further effect. Two commands acknowledge first and then pulse a power-down request or a system-reset request for one cycle. Any packet whose type is not the controller type, and any command code not listed below, gets an error reply and changes nothing.

The reply is a parallel word of up to seven bytes plus a length. The first byte to send sits in the most significant byte of `reply_data`, and bytes beyond the length read as zero.

Top module: `pkt_cmd_responder`

## Requirements
- R1: Each cycle with `pkt_valid` high produces `reply_valid` high for exactly the next cycle, and no reply appears without a packet. The reply's first byte is `reply_data[55:47+1]`, and bytes past `reply_len` are zero.
- R2: Type 1, command 0x01 turns polling on when `pkt_arg[31:24]` is nonzero and off when it is zero. The reply is 2 bytes: 0x01 0x00.
- R3: While polling is on, `poll_tick` is a one-cycle pulse every `CLK_HZ/POLL_HZ` cycles. The first pulse comes that many cycles after `autopoll_en` rises. While polling is off there are no pulses.
- R4: After reset the seconds count equals `UNIX_INIT + 2082844800` modulo 2^32. It increments by one on each cycle with `sec_tick` high, wraps from 0xFFFFFFFF to 0, and otherwise holds.
- R5: Type 1, command 0x09 loads the count from `pkt_arg`, with `pkt_arg[31:24]` as the most significant byte. A load beats a tick in the same cycle. The reply is 3 bytes: 0x01 0x00 0x09.
- R6: Type 1, command 0x03 replies with 7 bytes: 0x01 0x00 0x03 and then the count, most significant byte first. The count reported is the value held before any tick in the same cycle.
- R7: Type 1 with command 0x13, 0x14, 0x19 or 0x21 replies with 2 bytes, 0x01 0x00, and changes no state.
- R8: Type 1, command 0x0A replies with 0x01 0x00. `pwr_down_req` then pulses high for one cycle, in the cycle after `reply_valid`.
- R9: Type 1, command 0x11 replies with 0x01 0x00. `sys_reset_req` then pulses high for one cycle, in the cycle after `reply_valid`.
- R10: A packet whose type is not 1, or whose command is not listed above, replies with 2 bytes: 0x02 followed by the command byte. Polling, the seconds count and both request outputs are left unchanged.
- R11: During and just after reset, `reply_valid`, `reply_len`, `reply_data`, `autopoll_en`, `poll_tick`, `pwr_down_req` and `sys_reset_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | One-cycle strobe: a packet is present |
| pkt_type | input | 8 | Packet type byte |
| pkt_cmd | input | 8 | Command byte |
| pkt_arg | input | 32 | Argument bytes, first byte in [31:24] |
| sec_tick | input | 1 | One-per-second count enable |
| reply_valid | output | 1 | One-cycle strobe: reply ready |
| reply_len | output | 3 | Reply length in bytes (2, 3 or 7) |
| reply_data | output | 56 | Reply bytes, first byte in [55:48] |
| autopoll_en | output | 1 | Polling is on |
| poll_tick | output | 1 | Periodic poll pulse |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System-reset request pulse |

## Verification
The assertions assume that `pkt_valid` is a synchronous strobe, that the argument bytes are valid in the same cycle as the strobe, and that a new packet never arrives in the cycle a power or reset request is still pending. The power-sequence and one-hot checks depend on that last condition. The bench drives every input at the falling edge and sends packets with gaps between them, so the strobes never overlap. It raises `sec_tick` together with a packet only in the directed cases that test load-versus-tick priority and read-versus-tick priority.

// File: rtl/pktresp_pkg.sv
package pktresp_pkg;

   localparam logic [7:0] PT_BUS   = 8'h00;
   localparam logic [7:0] PT_CTRL  = 8'h01;
   localparam logic [7:0] PT_ERROR = 8'h02;

   localparam logic [7:0] OP_POLL      = 8'h01;
   localparam logic [7:0] OP_READ_SEC  = 8'h03;
   localparam logic [7:0] OP_LOAD_SEC  = 8'h09;
   localparam logic [7:0] OP_POWER_OFF = 8'h0A;
   localparam logic [7:0] OP_CFG_SRV   = 8'h13;
   localparam logic [7:0] OP_CFG_RATE  = 8'h14;
   localparam logic [7:0] OP_CFG_LIST  = 8'h19;
   localparam logic [7:0] OP_RESTART   = 8'h11;
   localparam logic [7:0] OP_CFG_MSGS  = 8'h21;

   localparam logic [31:0] EPOCH_GAP = 32'd2082844800;
   localparam int          MAX_BYTES = 7;

   typedef enum logic [2:0] {
      ACT_ERROR,
      ACT_ACK,
      ACT_POLL,
      ACT_LOAD,
      ACT_READ,
      ACT_POWER,
      ACT_RESTART
   } act_e;

endpackage

// File: rtl/pktresp_decode.sv
module pktresp_decode
   import pktresp_pkg::*;
(
   input  logic [7:0] ptype,
   input  logic [7:0] cmd,
   output act_e       act
);
   always_comb begin
      act = ACT_ERROR;
      if (ptype == PT_CTRL) begin
         case (cmd)
            OP_POLL:      act = ACT_POLL;
            OP_READ_SEC:  act = ACT_READ;
            OP_LOAD_SEC:  act = ACT_LOAD;
            OP_POWER_OFF: act = ACT_POWER;
            OP_RESTART:   act = ACT_RESTART;
            OP_CFG_SRV, OP_CFG_RATE,
            OP_CFG_LIST, OP_CFG_MSGS: act = ACT_ACK;
            default:      act = ACT_ERROR;
         endcase
      end
   end
endmodule

// File: rtl/pktresp_seconds.sv
module pktresp_seconds #(
   parameter int          SEC_W = 32,
   parameter logic [31:0] INIT  = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   output logic [SEC_W-1:0] sec
);
   logic [SEC_W-1:0] sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sec_q <= INIT[SEC_W-1:0];
      else if (load) sec_q <= load_val;
      else if (tick) sec_q <= sec_q + SEC_W'(1);
   end

   assign sec = sec_q;

   AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(sec)); // R4
   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (sec == $past(sec) + SEC_W'(1))); // R4
   AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sec == $past(load_val))); // R5
endmodule

// File: rtl/pktresp_poll.sv
module pktresp_poll #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic clr_en,
   output logic en,
   output logic tick
);
   localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic             en_q, en_n, tick_q;
   logic [CNT_W-1:0] cnt_q;

   assign en_n = set_en ? 1'b1 : (clr_en ? 1'b0 : en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         en_q <= en_n;
         if (!en_n || !en_q) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
         end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            tick_q <= 1'b0;
         end
      end
   end

   assign en   = en_q;
   assign tick = tick_q;

   AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick); // R3
   AST_POLL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/pktresp_build.sv
module pktresp_build
   import pktresp_pkg::*;
(
   input  act_e        act,
   input  logic [7:0]  cmd,
   input  logic [31:0] sec,
   output logic [2:0]  len,
   output logic [8*MAX_BYTES-1:0] data
);
   logic [7:0] bytes [MAX_BYTES];

   always_comb begin
      for (int i = 0; i < MAX_BYTES; i++) bytes[i] = 8'h00;
      len = 3'd2;
      bytes[0] = PT_CTRL;
      case (act)
         ACT_ERROR: begin
            bytes[0] = PT_ERROR;
            bytes[1] = cmd;
         end
         ACT_LOAD: begin
            len      = 3'd3;
            bytes[2] = OP_LOAD_SEC;
         end
         ACT_READ: begin
            len      = 3'd7;
            bytes[2] = OP_READ_SEC;
            bytes[3] = sec[31:24];
            bytes[4] = sec[23:16];
            bytes[5] = sec[15:8];
            bytes[6] = sec[7:0];
         end
         default: ;
      endcase
   end

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_flat
      assign data[8*(MAX_BYTES-1-g) +: 8] = bytes[g];
   end
endmodule

// File: rtl/pkt_cmd_responder.sv
module pkt_cmd_responder
   import pktresp_pkg::*;
#(
   parameter int          CLK_HZ    = 100_000_000,
   parameter int          POLL_HZ   = 50,
   parameter logic [31:0] UNIX_INIT = 32'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pkt_valid,
   input  logic [7:0]  pkt_type,
   input  logic [7:0]  pkt_cmd,
   input  logic [31:0] pkt_arg,
   input  logic        sec_tick,
   output logic        reply_valid,
   output logic [2:0]  reply_len,
   output logic [55:0] reply_data,
   output logic        autopoll_en,
   output logic        poll_tick,
   output logic        pwr_down_req,
   output logic        sys_reset_req
);
   localparam int          POLL_DIV = CLK_HZ / ((POLL_HZ > 0) ? POLL_HZ : 1);
   localparam logic [31:0] SEC_INIT = UNIX_INIT + EPOCH_GAP;

   if (POLL_HZ < 1 || POLL_DIV < 2) begin : g_bad_rate
      $error("pkt_cmd_responder: CLK_HZ/POLL_HZ must be at least 2");
   end

   act_e        act;
   logic [31:0] sec;
   logic [2:0]  b_len;
   logic [55:0] b_data;
   logic        rv_q, pwr_pend_q, rst_pend_q, pwr_q, rstq_q;
   logic [2:0]  len_q;
   logic [55:0] data_q;
   logic        do_poll, arg_on;

   pktresp_decode u_decode (.ptype(pkt_type), .cmd(pkt_cmd), .act(act));

   assign do_poll = pkt_valid && (act == ACT_POLL);
   assign arg_on  = (pkt_arg[31:24] != 8'h00);

   pktresp_seconds #(.SEC_W(32), .INIT(SEC_INIT)) u_seconds (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick),
      .load(pkt_valid && (act == ACT_LOAD)),
      .load_val(pkt_arg), .sec(sec)
   );

   pktresp_poll #(.DIV(POLL_DIV)) u_poll (
      .clk(clk), .rst_n(rst_n),
      .set_en(do_poll && arg_on), .clr_en(do_poll && !arg_on),
      .en(autopoll_en), .tick(poll_tick)
   );

   pktresp_build u_build (
      .act(act), .cmd(pkt_cmd), .sec(sec), .len(b_len), .data(b_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q       <= 1'b0;
         len_q      <= '0;
         data_q     <= '0;
         pwr_pend_q <= 1'b0;
         rst_pend_q <= 1'b0;
         pwr_q      <= 1'b0;
         rstq_q     <= 1'b0;
      end else begin
         rv_q       <= pkt_valid;
         pwr_pend_q <= pkt_valid && (act == ACT_POWER);
         rst_pend_q <= pkt_valid && (act == ACT_RESTART);
         pwr_q      <= pwr_pend_q;
         rstq_q     <= rst_pend_q;
         if (pkt_valid) begin
            len_q  <= b_len;
            data_q <= b_data;
         end
      end
   end

   assign reply_valid   = rv_q;
   assign reply_len     = len_q;
   assign reply_data    = data_q;
   assign pwr_down_req  = pwr_q;
   assign sys_reset_req = rstq_q;

   AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> reply_valid); // R1
   AST_NO_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !reply_valid); // R1
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      reply_valid |-> (reply_len == 3'd2 || reply_len == 3'd3 || reply_len == 3'd7)); // R1
   AST_PWR_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_req |-> ($past(reply_valid) && !reply_valid)); // R8
   AST_RST_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> ($past(reply_valid) && !reply_valid)); // R9
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pwr_down_req, sys_reset_req})); // R8
   AST_ERR_KEEPS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && act == ACT_ERROR) |=> $stable(autopoll_en)); // R10
endmodule

// File: tb/pkt_cmd_responder_bench.sv
module pkt_cmd_responder_bench;
   localparam int DIV = 10;
   localparam int NV  = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [7:0]  pkt_type = '0;
   logic [7:0]  pkt_cmd = '0;
   logic [31:0] pkt_arg = '0;
   logic        sec_tick = 1'b0;
   logic        reply_valid, autopoll_en, poll_tick, pwr_down_req, sys_reset_req;
   logic [2:0]  reply_len;
   logic [55:0] reply_data;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pkt_cmd_responder #(.CLK_HZ(DIV * 50), .POLL_HZ(50), .UNIX_INIT(32'd0)) u_pkt_cmd_responder (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
      .pkt_cmd(pkt_cmd), .pkt_arg(pkt_arg), .sec_tick(sec_tick),
      .reply_valid(reply_valid), .reply_len(reply_len), .reply_data(reply_data),
      .autopoll_en(autopoll_en), .poll_tick(poll_tick),
      .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req)
   );

   // type, cmd, arg, expected length, expected reply bytes
   localparam logic [106:0] VEC [NV] = '{
      {8'h01, 8'h13, 32'h0,        3'd2, 8'h01, 8'h00, 40'h0},
      {8'h01, 8'h14, 32'h0,        3'd2, 8'h01, 8'h00, 40'h0},
      {8'h01, 8'h19, 32'h0,        3'd2, 8'h01, 8'h00, 40'h0},
      {8'h01, 8'h21, 32'h0,        3'd2, 8'h01, 8'h00, 40'h0},
      {8'h01, 8'h07, 32'h0,        3'd2, 8'h02, 8'h07, 40'h0},
      {8'h00, 8'h01, 32'hFF000000, 3'd2, 8'h02, 8'h01, 40'h0},
      {8'h03, 8'h03, 32'h0,        3'd2, 8'h02, 8'h03, 40'h0},
      {8'h01, 8'h09, 32'h12345678, 3'd3, 8'h01, 8'h00, 8'h09, 32'h0},
      {8'h01, 8'h03, 32'h0,        3'd7, 8'h01, 8'h00, 8'h03, 32'h12345678},
      {8'h01, 8'h01, 32'h0,        3'd2, 8'h01, 8'h00, 40'h0}
   };

   function automatic string vec_tag(int i);
      if (i < 4)  return "R7";
      if (i < 7)  return "R10";
      if (i == 7) return "R5";
      if (i == 8) return "R6";
      return "R2";
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the reply sampled
   task automatic send(input logic [7:0] t, input logic [7:0] c, input logic [31:0] a,
                       output logic rv, output logic [2:0] l, output logic [55:0] d);
      pkt_type = t; pkt_cmd = c; pkt_arg = a; pkt_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pkt_valid = 1'b0;
      rv = reply_valid; l = reply_len; d = reply_data;
   endtask

   task automatic read_sec(output logic [31:0] s);
      logic rv; logic [2:0] l; logic [55:0] d;
      send(8'h01, 8'h03, 32'h0, rv, l, d);
      s = d[31:0];
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic rv; logic [2:0] l; logic [55:0] d; logic [31:0] s;
      int n;
      repeat (3) @(negedge clk);
      // R11 reset state
      check({reply_valid, reply_len, reply_data, autopoll_en, poll_tick, pwr_down_req, sys_reset_req} == '0,
            "R11", {reply_valid, reply_len, autopoll_en, poll_tick, pwr_down_req, sys_reset_req}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(reply_valid == 1'b0, "R11", reply_valid, 0);

      // R4 R6 initial seconds with 1904 epoch
      send(8'h01, 8'h03, 32'h0, rv, l, d);
      check(rv && l == 3'd7 && d == {8'h01, 8'h00, 8'h03, 32'h7C25B080}, "R6", d, {8'h01, 8'h00, 8'h03, 32'h7C25B080});
      @(negedge clk);
      check(reply_valid == 1'b0, "R1", reply_valid, 0);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][106:99], VEC[i][98:91], VEC[i][90:59], rv, l, d);
         check(rv == 1'b1, "R1", rv, 1);
         check(l == VEC[i][58:56] && d == VEC[i][55:0], vec_tag(i), {l, d}, VEC[i][58:0]);
         check(autopoll_en == 1'b0, vec_tag(i), autopoll_en, 0);
         @(negedge clk);
         check(pwr_down_req == 1'b0 && sys_reset_req == 1'b0, vec_tag(i), {pwr_down_req, sys_reset_req}, 0);
      end

      // R4 ticks count up
      send(8'h01, 8'h09, 32'h000000FF, rv, l, d);
      sec_tick = 1'b1;
      repeat (3) @(negedge clk);
      sec_tick = 1'b0;
      read_sec(s);
      check(s == 32'h102, "R4", s, 32'h102);
      // R6 read with a tick in the same cycle reports the old value
      sec_tick = 1'b1;
      send(8'h01, 8'h03, 32'h0, rv, l, d);
      sec_tick = 1'b0;
      check(d[31:0] == 32'h102, "R6", d[31:0], 32'h102);
      read_sec(s);
      check(s == 32'h103, "R6", s, 32'h103);
      // R5 load beats tick, R4 wrap
      sec_tick = 1'b1;
      send(8'h01, 8'h09, 32'hFFFFFFFF, rv, l, d);
      sec_tick = 1'b0;
      read_sec(s);
      check(s == 32'hFFFFFFFF, "R5", s, 32'hFFFFFFFF);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      read_sec(s);
      check(s == 32'h0, "R4", s, 32'h0);

      // R2 R3 polling on
      send(8'h01, 8'h01, 32'h01000000, rv, l, d);
      check(autopoll_en == 1'b1 && d == {8'h01, 8'h00, 40'h0}, "R2", {autopoll_en, d}, {1'b1, 8'h01, 8'h00, 40'h0});
      n = 0;
      do begin @(posedge clk); @(negedge clk); n++; end while (!poll_tick && n < 100);
      check(n == DIV, "R3", n, DIV);
      n = 0;
      do begin @(posedge clk); @(negedge clk); n++; end while (!poll_tick && n < 100);
      check(n == DIV, "R3", n, DIV);
      // R10 unknown command leaves polling on
      send(8'h01, 8'h55, 32'h0, rv, l, d);
      check(autopoll_en == 1'b1 && d[55:40] == 16'h0255, "R10", {autopoll_en, d[55:40]}, {1'b1, 16'h0255});
      // R2 polling off, R3 no pulses
      send(8'h01, 8'h01, 32'h00FFFFFF, rv, l, d);
      check(autopoll_en == 1'b0, "R2", autopoll_en, 0);
      n = 0;
      for (int k = 0; k < 3 * DIV; k++) begin
         if (poll_tick) n++;
         @(negedge clk);
      end
      check(n == 0, "R3", n, 0);

      // R8 power down
      send(8'h01, 8'h0A, 32'h0, rv, l, d);
      check(rv && l == 3'd2 && d == {8'h01, 8'h00, 40'h0} && !pwr_down_req, "R8", {pwr_down_req, d}, {1'b0, 8'h01, 8'h00, 40'h0});
      @(negedge clk);
      check(pwr_down_req && !reply_valid && !sys_reset_req, "R8", {pwr_down_req, sys_reset_req}, 2'b10);
      @(negedge clk);
      check(!pwr_down_req, "R8", pwr_down_req, 0);
      // R9 system reset
      send(8'h01, 8'h11, 32'h0, rv, l, d);
      check(rv && d == {8'h01, 8'h00, 40'h0} && !sys_reset_req, "R9", {sys_reset_req, d}, {1'b0, 8'h01, 8'h00, 40'h0});
      @(negedge clk);
      check(sys_reset_req && !pwr_down_req, "R9", {pwr_down_req, sys_reset_req}, 2'b01);
      @(negedge clk);
      check(!sys_reset_req, "R9", sys_reset_req, 0);
      // R10 error leaves seconds unchanged
      send(8'h04, 8'h09, 32'hAAAAAAAA, rv, l, d);
      check(d[55:40] == 16'h0209 && l == 3'd2, "R10", {l, d[55:40]}, {3'd2, 16'h0209});
      read_sec(s);
      check(s == 32'h0, "R10", s, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule